// File: doc/BRIEF.md
# Four-Channel Phase-Accumulator Waveform Engine

The engine produces four 16-bit sample words every clock, one per channel, for downstream converters. Each channel owns a 20-bit phase accumulator. Its step size comes from a per-channel base value, the 8-bit live control bus, three small modulation bits that act as phase nudges and, for channels 1 to 3, the top nibble of the previous channel's phase. Through that last term the channels modulate one another.

A free-running tempo divider emits a one-clock tick. The fast select gives it a short period and otherwise it runs slow. Each tick advances a 4-bit step counter and a shared 16-bit pseudo-random noise register. A 2-bit scene input rotates which shape each channel plays: saw, triangle, pulse-width or stepped. One scene swaps the last channel for noise. A freeze input stops all four accumulators while the tempo logic keeps running. The modulation bits are echoed back on a status output.

Top module: `pw_wave_engine`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the accumulators, the sample outputs, the step counter and the tick clear to zero, and the noise register loads 0xACE1.
- R2: On each clock with freeze low, accumulator k (k = 0..3) adds BASE_STEP*(k+1) + 4*live + mod, modulo 2^20. For k >= 1 it also adds bits [19:16] of accumulator k-1 as held before that clock.
- R3: While `freeze_i` is high the accumulators hold their values. The step counter and tick keep running.
- R4: Each sample output is registered. It shows the shape of the accumulator value held before the clock edge, using the scene and live inputs sampled at that edge.
- R5: With p = accumulator bits [19:4], the shapes are as follows. Saw = p. Triangle = {p[14:0],0} when p[15] is 0, and its bitwise inverse when p[15] is 1. Pulse = 0xFFFF when p[15:8] < live, else 0. Stepped = {p[15:12], 12 zero bits}.
- R6: Channel k plays shape (k + scene) mod 4, in the order saw=0, triangle=1, pulse=2, stepped=3. In scene 3, channel 3 outputs the noise register instead.
- R7: The tick is a one-clock pulse. Its period is 2^FAST_LOG2 clocks when `fast_i` is high and 2^SLOW_LOG2 otherwise. It is taken from a counter that starts at zero at reset, so the first tick appears 2^N clocks after reset is released.
- R8: The step counter advances by one on the same edge that raises the tick, and wraps from 15 to 0.
- R9: The noise register shifts left on each tick. Its new bit 0 is the XOR of bits 15, 14, 12 and 3.
- R10: `mod_mon_o` equals `mod_i` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scene_i | input | 2 | Shape rotation select |
| mod_i | input | 3 | Modulation bits added to every increment |
| live_i | input | 8 | Live control byte: increment offset and pulse threshold |
| fast_i | input | 1 | Short tempo period when high |
| freeze_i | input | 1 | Holds all accumulators while high |
| samples_o | output | 64 | Channel k sample in bits [16k+15:16k] |
| step_o | output | 4 | Current sequencer step |
| tick_o | output | 1 | Tempo tick pulse |
| mod_mon_o | output | 3 | Registered echo of mod_i |

## Verification
A tempo tick can land in the same cycle as a held freeze. The step counter and noise register must then move while the accumulators must not. The bench holds freeze across a full fast tempo period. It then checks that the channel 0 saw stays put while the step count climbs by exactly the number of ticks seen. A longer run with pseudo-random scene, freeze, fast and control changes compares every channel against an independent reference model each cycle. That run also covers fast-select switches landing in the middle of a divider period.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int NUM_CH = 4;
  localparam int STEP_BITS = 4;
  typedef enum logic [1:0] {
    SH_SAW  = 2'd0,
    SH_TRI  = 2'd1,
    SH_PWM  = 2'd2,
    SH_STEP = 2'd3
  } shape_e;
endpackage

// File: rtl/pw_tempo.sv
module pw_tempo #(
  parameter int FAST_LOG2 = 12,
  parameter int SLOW_LOG2 = 16,
  parameter int STEP_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fast_i,
  output logic              adv_o,
  output logic              tick_o,
  output logic [STEP_W-1:0] step_o
);
  logic [SLOW_LOG2-1:0] cnt_q;
  logic                 tick_q;
  logic [STEP_W-1:0]    step_q;
  logic                 tick_now;

  assign tick_now = fast_i ? (&cnt_q[FAST_LOG2-1:0]) : (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
      step_q <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= tick_now;
      if (tick_now) step_q <= step_q + 1'b1;
    end
  end

  assign adv_o  = tick_now;
  assign tick_o = tick_q;
  assign step_o = step_q;

  assert_tick_single_R7: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q);
  assert_step_adv_R8: assert property (@(posedge clk) disable iff (rst)
    tick_q |-> (step_q == STEP_W'($past(step_q) + 1'b1)));
  assert_step_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (step_q != $past(step_q)) |-> tick_q);
endmodule

// File: rtl/pw_lfsr.sv
module pw_lfsr #(
  parameter int           WIDTH    = 16,
  parameter logic [15:0]  SEED     = 16'hACE1,
  parameter logic [15:0]  TAP_MASK = 16'hD008
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q;
  logic             fb;

  assign fb = ^(q & WIDTH'(TAP_MASK));

  always_ff @(posedge clk) begin
    if (rst)       q <= WIDTH'(SEED);
    else if (en_i) q <= {q[WIDTH-2:0], fb};
  end

  assign q_o = q;

  assert_lfsr_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
    q != '0);
  assert_lfsr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(q));
endmodule

// File: rtl/pw_phase_acc.sv
module pw_phase_acc #(
  parameter int ACC_W   = 20,
  parameter int PHASE_W = 16,
  parameter int LIVE_W  = 8,
  parameter int MOD_W   = 3,
  parameter int XM_W    = 4,
  parameter int BASE    = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               freeze_i,
  input  logic [LIVE_W-1:0]  live_i,
  input  logic [MOD_W-1:0]   mod_i,
  input  logic [XM_W-1:0]    xmod_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] inc;

  assign inc = ACC_W'(BASE) + (ACC_W'(live_i) << 2) + ACC_W'(mod_i) + ACC_W'(xmod_i);

  always_ff @(posedge clk) begin
    if (rst)            acc_q <= '0;
    else if (!freeze_i) acc_q <= acc_q + inc;
  end

  assign phase_o = acc_q[ACC_W-1 -: PHASE_W];

  assert_freeze_hold_R3: assert property (@(posedge clk) disable iff (rst)
    freeze_i |=> $stable(acc_q));
endmodule

// File: rtl/pw_shaper.sv
module pw_shaper
  import pw_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int LIVE_W   = 8,
  parameter int CH       = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          scene_i,
  input  logic [LIVE_W-1:0]   live_i,
  input  logic [SAMPLE_W-1:0] phase_i,
  input  logic [SAMPLE_W-1:0] noise_i,
  output logic [SAMPLE_W-1:0] sample_o
);
  localparam logic [1:0] CH_L = 2'(CH);
  logic [1:0]          sel_raw;
  shape_e              sel;
  logic                use_noise;
  logic [SAMPLE_W-1:0] shaped;
  logic [SAMPLE_W-1:0] sample_q;

  assign sel_raw   = scene_i + CH_L;
  assign sel       = shape_e'(sel_raw);
  assign use_noise = (scene_i == 2'd3) && (CH == NUM_CH - 1);

  always_comb begin
    unique case (sel)
      SH_SAW:  shaped = phase_i;
      SH_TRI:  shaped = phase_i[SAMPLE_W-1] ? ~{phase_i[SAMPLE_W-2:0], 1'b0}
                                            :  {phase_i[SAMPLE_W-2:0], 1'b0};
      SH_PWM:  shaped = (phase_i[SAMPLE_W-1 -: LIVE_W] < live_i) ? '1 : '0;
      default: shaped = {phase_i[SAMPLE_W-1 -: STEP_BITS], {(SAMPLE_W-STEP_BITS){1'b0}}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sample_q <= '0;
    else     sample_q <= use_noise ? noise_i : shaped;
  end

  assign sample_o = sample_q;

  assert_pwm_rail_R5: assert property (@(posedge clk) disable iff (rst)
    (sel == SH_PWM && !use_noise) |=> (sample_q == '0 || sample_q == '1));
endmodule

// File: rtl/pw_wave_engine.sv
module pw_wave_engine
  import pw_pkg::*;
#(
  parameter int ACC_W     = 20,
  parameter int SAMPLE_W  = 16,
  parameter int LIVE_W    = 8,
  parameter int MOD_W     = 3,
  parameter int XM_W      = 4,
  parameter int BASE_STEP = 256,
  parameter int FAST_LOG2 = 12,
  parameter int SLOW_LOG2 = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   scene_i,
  input  logic [MOD_W-1:0]             mod_i,
  input  logic [LIVE_W-1:0]            live_i,
  input  logic                         fast_i,
  input  logic                         freeze_i,
  output logic [NUM_CH*SAMPLE_W-1:0]   samples_o,
  output logic [STEP_BITS-1:0]         step_o,
  output logic                         tick_o,
  output logic [MOD_W-1:0]             mod_mon_o
);
  logic                adv;
  logic [SAMPLE_W-1:0] noise;
  logic [SAMPLE_W-1:0] phase [NUM_CH];
  logic [XM_W-1:0]     xmod  [NUM_CH];

  pw_tempo #(.FAST_LOG2(FAST_LOG2), .SLOW_LOG2(SLOW_LOG2), .STEP_W(STEP_BITS)) u_tempo (
    .clk(clk), .rst(rst), .fast_i(fast_i), .adv_o(adv), .tick_o(tick_o), .step_o(step_o)
  );

  pw_lfsr #(.WIDTH(SAMPLE_W)) u_noise (
    .clk(clk), .rst(rst), .en_i(adv), .q_o(noise)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    if (k == 0) begin : g_head
      assign xmod[k] = '0;
    end else begin : g_chain
      assign xmod[k] = phase[k-1][SAMPLE_W-1 -: XM_W];
    end

    pw_phase_acc #(
      .ACC_W(ACC_W), .PHASE_W(SAMPLE_W), .LIVE_W(LIVE_W), .MOD_W(MOD_W),
      .XM_W(XM_W), .BASE(BASE_STEP * (k + 1))
    ) u_acc (
      .clk(clk), .rst(rst), .freeze_i(freeze_i), .live_i(live_i), .mod_i(mod_i),
      .xmod_i(xmod[k]), .phase_o(phase[k])
    );

    pw_shaper #(.SAMPLE_W(SAMPLE_W), .LIVE_W(LIVE_W), .CH(k)) u_shape (
      .clk(clk), .rst(rst), .scene_i(scene_i), .live_i(live_i), .phase_i(phase[k]),
      .noise_i(noise), .sample_o(samples_o[k*SAMPLE_W +: SAMPLE_W])
    );
  end

  always_ff @(posedge clk) mod_mon_o <= mod_i;

  assert_mirror_R10: assert property (@(posedge clk) disable iff (rst)
    mod_mon_o == $past(mod_i));
endmodule

// File: tb/tb_pw_wave_engine.sv
module tb_pw_wave_engine;
  localparam int FASTL = 3;
  localparam int SLOWL = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  scene = '0;
  logic [2:0]  mod = '0;
  logic [7:0]  live = '0;
  logic        fast = 1'b0;
  logic        freeze = 1'b0;
  logic [63:0] samples;
  logic [3:0]  step;
  logic        tick;
  logic [2:0]  mod_mon;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pw_wave_engine #(.FAST_LOG2(FASTL), .SLOW_LOG2(SLOWL)) dut (
    .clk(clk), .rst(rst), .scene_i(scene), .mod_i(mod), .live_i(live), .fast_i(fast),
    .freeze_i(freeze), .samples_o(samples), .step_o(step), .tick_o(tick), .mod_mon_o(mod_mon)
  );

  function automatic logic [15:0] f_shape(input int sel, input logic [19:0] a, input logic [7:0] lv);
    logic [15:0] p;
    p = a[19:4];
    case (sel)
      0: return p;
      1: return p[15] ? ~{p[14:0], 1'b0} : {p[14:0], 1'b0};
      2: return (p[15:8] < lv) ? 16'hFFFF : 16'h0000;
      default: return {p[15:12], 12'h000};
    endcase
  endfunction

  // reference model built from the requirement formulas
  logic [19:0]     m_acc [4];
  logic [15:0]     m_smp [4];
  logic [SLOWL-1:0] m_cnt;
  logic [15:0]     m_lfsr;
  logic [3:0]      m_step;
  logic            m_tick;

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 4; k++) begin m_acc[k] <= '0; m_smp[k] <= '0; end
      m_cnt <= '0; m_lfsr <= 16'hACE1; m_step <= '0; m_tick <= 1'b0;
    end else begin
      logic tn;
      tn = fast ? (m_cnt[FASTL-1:0] == '1) : (m_cnt == '1);
      for (int k = 0; k < 4; k++) begin
        logic [19:0] inc;
        inc = 20'(256 * (k + 1)) + 20'({live, 2'b00}) + 20'(mod)
            + ((k > 0) ? 20'(m_acc[(k + 3) % 4][19:16]) : 20'd0);
        m_smp[k] <= (scene == 2'd3 && k == 3) ? m_lfsr : f_shape((k + scene) % 4, m_acc[k], live);
        if (!freeze) m_acc[k] <= m_acc[k] + inc;
      end
      m_cnt  <= m_cnt + 1'b1;
      m_tick <= tn;
      if (tn) begin
        m_step <= m_step + 1'b1;
        m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[14] ^ m_lfsr[12] ^ m_lfsr[3]};
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0]  sc;
    logic [7:0]  lv;
    logic [2:0]  md;
    logic [15:0] n;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 8'h00, 3'd0, 16'd10},
    '{2'd0, 8'hFF, 3'd7, 16'd40},
    '{2'd1, 8'h40, 3'd3, 16'd300},
    '{2'd2, 8'h80, 3'd1, 16'd200},
    '{2'd2, 8'h00, 3'd0, 16'd50},
    '{2'd3, 8'h12, 3'd5, 16'd777}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state while reset is held
    @(negedge clk); @(negedge clk);
    check("R1 samples in reset", samples, 64'h0);
    check("R1 step in reset", 64'(step), 64'h0);
    check("R1 tick in reset", 64'(tick), 64'h0);

    // vector table: channel 0 closed form, (N-1) updates seen after N edges (R2 R4 R5 R6)
    for (int v = 0; v < 6; v++) begin
      logic [19:0] a;
      logic [19:0] inc0;
      scene = VECS[v].sc; live = VECS[v].lv; mod = VECS[v].md; fast = 1'b0; freeze = 1'b0;
      do_reset();
      repeat (int'(VECS[v].n)) @(negedge clk);
      inc0 = 20'd256 + 20'({VECS[v].lv, 2'b00}) + 20'(VECS[v].md);
      a = 20'(inc0 * 20'(VECS[v].n - 16'd1));
      check($sformatf("R2/R5/R6 vector %0d ch0", v), 64'(samples[15:0]),
            64'(f_shape(int'(VECS[v].sc), a, VECS[v].lv)));
    end

    // R7: fast tick timing and width
    begin
      int first = 0;
      int second = 0;
      int wide = 0;
      fast = 1'b1; scene = 0; live = 0; mod = 0;
      do_reset();
      for (int i = 1; i <= 20; i++) begin
        @(negedge clk);
        if (tick) begin
          if (first == 0) first = i; else if (second == 0) second = i;
        end
        if (i == 9) wide = int'(tick);
      end
      check("R7 fast first tick", 64'(first), 64'd8);
      check("R7 fast period", 64'(second - first), 64'd8);
      check("R7 single-cycle tick", 64'(wide), 64'd0);
    end

    // R7: slow tick timing
    begin
      int first = 0;
      int second = 0;
      fast = 1'b0;
      do_reset();
      for (int i = 1; i <= 70; i++) begin
        @(negedge clk);
        if (tick) begin
          if (first == 0) first = i; else if (second == 0) second = i;
        end
      end
      check("R7 slow first tick", 64'(first), 64'd32);
      check("R7 slow period", 64'(second - first), 64'd32);
    end

    // R8: step follows ticks and wraps
    begin
      int nt = 0;
      fast = 1'b1;
      do_reset();
      while (nt < 17) begin
        @(negedge clk);
        if (tick) begin
          nt++;
          if (nt == 15 || nt == 16 || nt == 17)
            check($sformatf("R8 step after tick %0d", nt), 64'(step), 64'(nt % 16));
        end
      end
    end

    // R9: seed then first shift, seen on channel 3 in scene 3
    scene = 2'd3; fast = 1'b1;
    do_reset();
    @(negedge clk);
    check("R9 noise seed", 64'(samples[63:48]), 64'h ACE1);
    repeat (8) @(negedge clk);
    check("R9 noise after first tick", 64'(samples[63:48]), 64'h59C3);

    // R3: freeze held across a tick: saw stable, step advances
    begin
      logic [15:0] held;
      logic [3:0]  s0;
      int          nt = 0;
      scene = 0; live = 8'h21; mod = 3'd2; fast = 1'b1;
      do_reset();
      repeat (13) @(negedge clk);
      freeze = 1'b1;
      @(negedge clk);
      held = samples[15:0];
      s0 = step;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (tick) nt++;
      end
      check("R3 saw held under freeze", 64'(samples[15:0]), 64'(held));
      check("R3 step runs under freeze", 64'(4'(step - s0)), 64'(nt));
      check("R3 tick seen under freeze", 64'(nt > 0), 64'd1);
      freeze = 1'b0;
    end

    // R10: mirror
    @(negedge clk); mod = 3'd5;
    @(negedge clk);
    check("R10 mirror 5", 64'(mod_mon), 64'd5);
    mod = 3'd2;
    @(negedge clk);
    check("R10 mirror 2", 64'(mod_mon), 64'd2);

    // long pseudo-random run against the reference model (R2 R4 R6 R7 R8 R9)
    begin
      logic [31:0] lcg = 32'h1234_5678;
      int bad = 0;
      do_reset();
      for (int i = 0; i < 1500; i++) begin
        @(negedge clk);
        if ({samples, step, tick} !== {m_smp[3], m_smp[2], m_smp[1], m_smp[0], m_step, m_tick}) begin
          bad++;
          if (bad < 5)
            $display("FAIL R2/R6/R9 model cycle %0d actual=%h expected=%h", i, {samples, step, tick},
                     {m_smp[3], m_smp[2], m_smp[1], m_smp[0], m_step, m_tick});
        end
        if (i % 7 == 0) begin
          lcg = lcg * 32'd1103515245 + 32'd12345;
          scene = lcg[17:16]; live = lcg[25:18]; mod = lcg[28:26];
          freeze = (lcg[31:29] == 3'd0);
          fast = lcg[15];
        end
      end
      tests++;
      if (bad != 0) begin
        fails++;
        $display("FAIL R4 model run actual=%0d mismatches expected=0", bad);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule